// File: doc/BRIEF.md
# Cross-Bus Signal Interrupt Register

This block lets a master on a remote bus send signals to a local processor. It holds four signal flags. A write of one from the remote port sets a flag, and a set flag holds an interrupt request toward the local interrupt logic until the local processor clears it. Only the local port can clear a flag. It can do so in two ways: by writing one to the flag's own bit in the signal word, or by writing one to the matching bit of a separate clear word.

Both ports are simple register interfaces. Each has a single-cycle write strobe, byte-lane enables, a word address and a read-data bus that reflects the addressed word combinationally. Reads have no side effects. The block also serves a fixed identification byte and four read-only location-monitor status bits. The monitor bits are sampled from an input driven by address-match logic outside the block. Interrupts leave the block on one level output per flag and on one combined output.

Top module: `xbus_sig_regs`

## Requirements
- R1: A remote write to the signal word (rmt_addr=1) with lane 1 enabled sets flag i for every bit 8+i of rmt_wdata that is 1. A bit that is 0 leaves its flag as it was.
- R2: A remote write cannot clear any flag. A remote write with lane 1 disabled, or a remote write to the ID word (rmt_addr=0), changes nothing.
- R3: A local write to the signal word (loc_addr=1) with lane 1 enabled clears flag i for every bit 8+i of loc_wdata that is 1. The same write with lane 1 disabled has no effect.
- R4: A local write to the clear word (loc_addr=2) with lane 0 enabled clears flag i for every bit i of loc_wdata that is 1.
- R5: No local write sets a flag. This covers writes of zeros, writes to the ID word, writes to the clear word and writes to the unused word (loc_addr=3).
- R6: When a remote set and a local clear (through either path) reach the same flag in the same cycle, the flag ends up set.
- R7: irq_flag[i] is high exactly while flag i is set. irq_any is high exactly while any flag is set. Both change in the cycle after the write.
- R8: During reset every flag is 0 and the four monitor bits read as 1.
- R9: The ID word (address 0 on either port) reads 0x000A at all times. Writes to it are ignored.
- R10: The signal word reads with monitor bits at 15:12, flags at 11:8 and zeros at 7:0. The monitor bits show mon_stat as registered one cycle earlier. The clear word and the unused local word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmt_wr | input | 1 | Remote write strobe, one cycle |
| rmt_addr | input | 1 | Remote word select: 0 ID, 1 signal word |
| rmt_be | input | 2 | Remote byte-lane enables |
| rmt_wdata | input | 16 | Remote write data |
| rmt_rdata | output | 16 | Remote read data of addressed word |
| loc_wr | input | 1 | Local write strobe, one cycle |
| loc_addr | input | 2 | Local word select: 0 ID, 1 signal, 2 clear, 3 unused |
| loc_be | input | 2 | Local byte-lane enables |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data of addressed word |
| mon_stat | input | 4 | Location-monitor status from external match logic |
| irq_flag | output | 4 | Per-flag interrupt request, level |
| irq_any | output | 1 | OR of all flag requests, level |

## Verification
Every one of the sixteen remote set patterns is applied from an empty state. Each is then followed by every one of the sixteen clear patterns, once through the signal word and once through the clear word. These sweeps tell a correct per-bit set or clear apart from a shifted, inverted or merged mask. Remote writes that should do nothing are tried with lane 1 off and against the ID word. Local writes of zeros and to the ID, clear and unused words are also tried. Together these separate a port that can set from one that can only clear. A full sixteen-by-sixteen sweep of simultaneous set and clear, with the clear path alternating, separates set-wins priority from clear-wins priority.

// File: rtl/xsig_pkg.sv
package xsig_pkg;
    localparam int XS_DW       = 16;
    localparam int XS_NFLAG    = 4;
    localparam int XS_NMON     = 4;
    localparam int XS_FLAG_LSB = 8;
    localparam int XS_MON_LSB  = 12;
    localparam int XS_CLR_LSB  = 0;
    localparam logic [7:0] XS_ID_VAL = 8'd10;

    typedef enum logic [1:0] {
        LW_ID  = 2'd0,
        LW_SIG = 2'd1,
        LW_CLR = 2'd2,
        LW_RSV = 2'd3
    } loc_word_e;
endpackage

// File: rtl/xsig_flag_bank.sv
module xsig_flag_bank #(
    parameter int NFLAG = 4,
    parameter int NMON  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_mask,
    input  logic [NFLAG-1:0] clr_mask,
    input  logic [NMON-1:0]  mon_in,
    output logic [NFLAG-1:0] flag_o,
    output logic [NMON-1:0]  mon_o
);
    typedef struct packed {
        logic [NFLAG-1:0] flag;
        logic [NMON-1:0]  mon;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NFLAG; i++) begin
            // a set in the same cycle as a clear wins
            st_d.flag[i] = set_mask[i] | (st_q.flag[i] & ~clr_mask[i]);
        end
        st_d.mon = mon_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.mon  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag_out
        assign flag_o[g] = st_q.flag[g];
    end
    assign mon_o = st_q.mon;
endmodule

// File: rtl/xsig_rmt_port.sv
module xsig_rmt_port import xsig_pkg::*; #(
    parameter int DW    = 16,
    parameter int NFLAG = 4,
    parameter int NMON  = 4
) (
    input  logic              wr,
    input  logic              addr,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     wdata,
    input  logic [NFLAG-1:0]  flags,
    input  logic [NMON-1:0]   mon,
    output logic [NFLAG-1:0]  set_mask,
    output logic [DW-1:0]     rdata
);
    localparam int FLAG_LANE = XS_FLAG_LSB / 8;

    logic sig_hit;
    logic unused_rmt;

    assign sig_hit    = wr & addr & be[FLAG_LANE];
    assign set_mask   = sig_hit ? wdata[XS_FLAG_LSB +: NFLAG] : '0;
    assign unused_rmt = ^{wdata, be};

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[XS_FLAG_LSB +: NFLAG] = flags;
            rdata[XS_MON_LSB +: NMON]   = mon;
        end else begin
            rdata[7:0] = XS_ID_VAL;
        end
    end
endmodule

// File: rtl/xsig_loc_port.sv
module xsig_loc_port import xsig_pkg::*; #(
    parameter int DW    = 16,
    parameter int NFLAG = 4,
    parameter int NMON  = 4
) (
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DW/8-1:0]   be,
    input  logic [DW-1:0]     wdata,
    input  logic [NFLAG-1:0]  flags,
    input  logic [NMON-1:0]   mon,
    output logic [NFLAG-1:0]  clr_mask,
    output logic [DW-1:0]     rdata
);
    localparam int FLAG_LANE = XS_FLAG_LSB / 8;
    localparam int CLR_LANE  = XS_CLR_LSB / 8;

    loc_word_e        word;
    logic [NFLAG-1:0] sig_clr;
    logic [NFLAG-1:0] reg_clr;
    logic             unused_loc;

    assign word = loc_word_e'(addr);

    always_comb begin
        sig_clr = '0;
        reg_clr = '0;
        if (wr && word == LW_SIG && be[FLAG_LANE])
            sig_clr = wdata[XS_FLAG_LSB +: NFLAG];
        if (wr && word == LW_CLR && be[CLR_LANE])
            reg_clr = wdata[XS_CLR_LSB +: NFLAG];
    end

    assign clr_mask   = sig_clr | reg_clr;
    assign unused_loc = ^{wdata, be};

    always_comb begin
        rdata = '0;
        case (word)
            LW_ID:   rdata[7:0] = XS_ID_VAL;
            LW_SIG: begin
                rdata[XS_FLAG_LSB +: NFLAG] = flags;
                rdata[XS_MON_LSB +: NMON]   = mon;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/xbus_sig_regs.sv
module xbus_sig_regs import xsig_pkg::*; #(
    parameter int DW    = XS_DW,
    parameter int NFLAG = XS_NFLAG,
    parameter int NMON  = XS_NMON
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rmt_wr,
    input  logic              rmt_addr,
    input  logic [DW/8-1:0]   rmt_be,
    input  logic [DW-1:0]     rmt_wdata,
    output logic [DW-1:0]     rmt_rdata,
    input  logic              loc_wr,
    input  logic [1:0]        loc_addr,
    input  logic [DW/8-1:0]   loc_be,
    input  logic [DW-1:0]     loc_wdata,
    output logic [DW-1:0]     loc_rdata,
    input  logic [NMON-1:0]   mon_stat,
    output logic [NFLAG-1:0]  irq_flag,
    output logic              irq_any
);
    logic [NFLAG-1:0] set_mask;
    logic [NFLAG-1:0] clr_mask;
    logic [NFLAG-1:0] flags;
    logic [NMON-1:0]  mon;

    xsig_rmt_port #(.DW(DW), .NFLAG(NFLAG), .NMON(NMON)) u_rmt (
        .wr(rmt_wr), .addr(rmt_addr), .be(rmt_be), .wdata(rmt_wdata),
        .flags(flags), .mon(mon), .set_mask(set_mask), .rdata(rmt_rdata)
    );

    xsig_loc_port #(.DW(DW), .NFLAG(NFLAG), .NMON(NMON)) u_loc (
        .wr(loc_wr), .addr(loc_addr), .be(loc_be), .wdata(loc_wdata),
        .flags(flags), .mon(mon), .clr_mask(clr_mask), .rdata(loc_rdata)
    );

    xsig_flag_bank #(.NFLAG(NFLAG), .NMON(NMON)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
        .mon_in(mon_stat), .flag_o(flags), .mon_o(mon)
    );

    assign irq_flag = flags;
    assign irq_any  = |flags;
endmodule

// File: rtl/xsig_checker.sv
module xsig_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rmt_wr,
    input logic        rmt_addr,
    input logic [1:0]  rmt_be,
    input logic [15:0] rmt_wdata,
    input logic        loc_wr,
    input logic [1:0]  loc_addr,
    input logic [1:0]  loc_be,
    input logic [15:0] loc_wdata,
    input logic [15:0] loc_rdata,
    input logic [3:0]  irq_flag,
    input logic        irq_any
);
    logic       rmt_sig_wr;
    logic [3:0] rmt_bits;
    assign rmt_sig_wr = rmt_wr && rmt_addr && rmt_be[1];
    assign rmt_bits   = rmt_sig_wr ? rmt_wdata[11:8] : 4'h0;

    // R1
    rmt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_sig_wr && !loc_wr) |=> ((irq_flag & $past(rmt_wdata[11:8])) == $past(rmt_wdata[11:8])));

    // R3
    loc_sig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && loc_addr == 2'd1 && loc_be[1] && !rmt_wr) |=> ((irq_flag & $past(loc_wdata[11:8])) == 4'h0));

    // R4
    loc_reg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && loc_addr == 2'd2 && loc_be[0] && !rmt_wr) |=> ((irq_flag & $past(loc_wdata[3:0])) == 4'h0));

    // R5
    no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_flag & ~$past(irq_flag) & ~$past(rmt_bits)) == 4'h0));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_sig_wr && loc_wr) |=> ((irq_flag & $past(rmt_wdata[11:8])) == $past(rmt_wdata[11:8])));

    // R7
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == ($countones(irq_flag) != 0));

    // R9
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr == 2'd0) |-> (loc_rdata == 16'h000A));
endmodule

bind xbus_sig_regs xsig_checker u_xsig_chk (
    .clk(clk), .rst_n(rst_n), .rmt_wr(rmt_wr), .rmt_addr(rmt_addr),
    .rmt_be(rmt_be), .rmt_wdata(rmt_wdata), .loc_wr(loc_wr),
    .loc_addr(loc_addr), .loc_be(loc_be), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .irq_flag(irq_flag), .irq_any(irq_any)
);

// File: tb/test_xbus_sig_regs.sv
module test_xbus_sig_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rmt_wr = 1'b0;
    logic        rmt_addr = 1'b0;
    logic [1:0]  rmt_be = 2'b00;
    logic [15:0] rmt_wdata = '0;
    logic [15:0] rmt_rdata;
    logic        loc_wr = 1'b0;
    logic [1:0]  loc_addr = 2'd0;
    logic [1:0]  loc_be = 2'b00;
    logic [15:0] loc_wdata = '0;
    logic [15:0] loc_rdata;
    logic [3:0]  mon_stat = 4'h0;
    logic [3:0]  irq_flag;
    logic        irq_any;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_flags = 4'h0;
    logic [3:0] mon_val = 4'hF;

    xbus_sig_regs i_xbus_sig_regs (
        .clk(clk), .rst_n(rst_n),
        .rmt_wr(rmt_wr), .rmt_addr(rmt_addr), .rmt_be(rmt_be),
        .rmt_wdata(rmt_wdata), .rmt_rdata(rmt_rdata),
        .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_be(loc_be),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .mon_stat(mon_stat), .irq_flag(irq_flag), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        rmt_wr = 1'b0;
        loc_wr = 1'b0;
    endtask

    task automatic verify(input string tag);
        check(tag, {28'h0, irq_flag}, {28'h0, exp_flags});
        check("R7 irq_any", {31'h0, irq_any}, {31'h0, |exp_flags});
        loc_addr = 2'd1;
        rmt_addr = 1'b1;
        #1;
        check("R10 local signal word", {16'h0, loc_rdata}, {16'h0, mon_val, exp_flags, 8'h00});
        check("R10 remote signal word", {16'h0, rmt_rdata}, {16'h0, mon_val, exp_flags, 8'h00});
    endtask

    task automatic rmt_op(input logic a, input logic [1:0] be, input logic [15:0] d);
        rmt_wr = 1'b1; rmt_addr = a; rmt_be = be; rmt_wdata = d;
        step();
    endtask

    task automatic loc_op(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        loc_wr = 1'b1; loc_addr = a; loc_be = be; loc_wdata = d;
        step();
    endtask

    task automatic clear_all();
        loc_op(2'd2, 2'b01, 16'h000F);
        exp_flags = 4'h0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // reset phase
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 flags in reset", {28'h0, irq_flag}, 32'h0);
        check("R8 irq_any in reset", {31'h0, irq_any}, 32'h0);
        loc_addr = 2'd1; #1;
        check("R8 monitor bits in reset", {16'h0, loc_rdata}, 32'h0000F000);
        loc_addr = 2'd0; rmt_addr = 1'b0; #1;
        check("R9 local ID", {16'h0, loc_rdata}, 32'h0000000A);
        check("R9 remote ID", {16'h0, rmt_rdata}, 32'h0000000A);
        @(negedge clk);
        rst_n = 1'b1;
        mon_stat = 4'h5;
        loc_addr = 2'd1; #1;
        check("R10 monitor before sample", {16'h0, loc_rdata}, 32'h0000F000);
        step();
        mon_val = 4'h5;
        verify("R10 monitor sampled");
        mon_stat = 4'hA; #1;
        check("R10 monitor one cycle late", {16'h0, loc_rdata}, 32'h00005000);
        step();
        mon_val = 4'hA;
        verify("R10 monitor follows");
        loc_addr = 2'd2; #1;
        check("R10 clear word reads zero", {16'h0, loc_rdata}, 32'h0);
        loc_addr = 2'd3; #1;
        check("R10 unused word reads zero", {16'h0, loc_rdata}, 32'h0);

        for (int v = 0; v < 16; v++) begin
            clear_all();
            verify("R4 clear all");
            rmt_op(1'b1, 2'b10, {4'h0, v[3:0], 8'h00});
            exp_flags = v[3:0];
            verify("R1 remote set");
            rmt_op(1'b1, 2'b11, 16'hF0FF);
            verify("R1 zero bits keep flags");
            rmt_op(1'b1, 2'b01, 16'hFFFF);
            verify("R2 remote lane off");
            rmt_op(1'b0, 2'b11, 16'hFFFF);
            verify("R2 remote write to ID");
            rmt_addr = 1'b0; #1;
            check("R9 remote ID after write", {16'h0, rmt_rdata}, 32'h0000000A);
            loc_op(2'd0, 2'b11, 16'hFFFF);
            verify("R5 local write to ID");
            loc_addr = 2'd0; #1;
            check("R9 local ID after write", {16'h0, loc_rdata}, 32'h0000000A);
            loc_op(2'd2, 2'b11, 16'hFFF0);
            verify("R5 clear word zeros");
            loc_op(2'd1, 2'b11, 16'hF0FF);
            verify("R5 signal word zeros");
            loc_op(2'd1, 2'b01, 16'hFFFF);
            verify("R3 local lane off");
            loc_op(2'd3, 2'b11, 16'hFFFF);
            verify("R5 unused word");
            for (int u = 0; u < 16; u++) begin
                rmt_op(1'b1, 2'b10, {4'h0, v[3:0], 8'h00});
                exp_flags = exp_flags | v[3:0];
                loc_op(2'd1, 2'b10, {4'h0, u[3:0], 8'h00});
                exp_flags = exp_flags & ~u[3:0];
                verify("R3 clear via signal word");
                rmt_op(1'b1, 2'b10, {4'h0, v[3:0], 8'h00});
                exp_flags = exp_flags | v[3:0];
                loc_op(2'd2, 2'b01, {12'h0, u[3:0]});
                exp_flags = exp_flags & ~u[3:0];
                verify("R4 clear via clear word");
            end
        end

        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                rmt_op(1'b1, 2'b10, 16'h0F00);
                exp_flags = 4'hF;
                rmt_wr = 1'b1; rmt_addr = 1'b1; rmt_be = 2'b10;
                rmt_wdata = {4'h0, s[3:0], 8'h00};
                loc_wr = 1'b1;
                if (s[0]) begin
                    loc_addr = 2'd1; loc_be = 2'b10; loc_wdata = {4'h0, c[3:0], 8'h00};
                end else begin
                    loc_addr = 2'd2; loc_be = 2'b01; loc_wdata = {12'h0, c[3:0]};
                end
                step();
                exp_flags = (4'hF & ~c[3:0]) | s[3:0];
                verify("R6 set wins over clear");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule